// File: doc/BRIEF.md
# Indexed Address-Attribute Register Pair

This block holds two 64-bit address-attribute entries behind a small index register. The entries are reached through the kind of register port a coprocessor offers. A host moves the index to pick an entry. It then writes the low or the high half of that entry, and it reads the selected entry back in three forms: the low word sign-extended, the high part shifted down, or all 64 bits. Every write is masked, so only the implemented fields can hold ones.

Entry 0 describes a storage window. Bit 0 enables the window, bits 5..1 give the window size as a power-of-two exponent, and bits 43..12 hold the window base. These fields are brought out as separate outputs. Any write to entry 0 produces a one-cycle reconfigure strobe, which tells a downstream address decoder to load the new window. Entry 1 is general attribute storage and does not drive the strobe.

Top module: `aar_regpair`

## Requirements
- R1: After reset the index reads 0 and entry 1 reads zero. The strobe is low. When the window is present (the default), entry 0 reads 0x22, which means window size exponent 17 with the window disabled.
- R2: An index write looks only at data bits 5..0. It is taken only when that value is 0 or 1. A value of 2 or more leaves the index as it was, and data bits above bit 5 have no effect.
- R3: A low-half write stores the data ANDed with 0x00000FFFFFFFF03F into the selected entry.
- R4: A high-half write copies data bits 11..0 into entry bits 43..32. Entry bits 31..0 are kept, and bits 63..44 stay zero.
- R5: The low read returns entry bits 31..0, sign-extended from bit 31 to 64 bits.
- R6: The high read returns the entry shifted right by 32. The full read returns the entry unchanged.
- R7: A write of either half while the index is 0 raises the reconfigure strobe for exactly the one cycle after the edge that stores the data. A write to entry 1 leaves the strobe low.
- R8: The window outputs follow entry 0 after each edge: enable from bit 0, size from bits 5..1, base from bits 43..12.
- R9: A data write in the same cycle as an index write goes to the entry picked by the old index. When a low-half write and a high-half write arrive in the same cycle, bits 43..32 come from the high-half write.
- R10: A write to entry 1 leaves entry 0 and the window outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_we | input | 1 | Write the index from wdata[5:0] |
| lo_we | input | 1 | Low-half write to the selected entry |
| hi_we | input | 1 | High-half write to the selected entry |
| wdata | input | 64 | Write data |
| idx_o | output | 6 | Current index |
| rd_full_o | output | 64 | Selected entry, all 64 bits |
| rd_lo_o | output | 64 | Low word of the selected entry, sign-extended |
| rd_hi_o | output | 64 | Selected entry shifted right by 32 |
| reconf_o | output | 1 | One-cycle strobe after a write to entry 0 |
| win_en_o | output | 1 | Window enable from entry 0 |
| win_size_o | output | 5 | Window size exponent from entry 0 |
| win_base_o | output | 32 | Window base from entry 0 |

## Verification
Low-half writes are driven with all-ones data, which shows which bits the mask clears. They are also driven with a positive word, so that the two cases of sign extension can be told apart. High-half writes carry junk in the bits above bit 11. This shows that only the 12-bit field lands and that the low word survives. Index writes are driven with 5, 0x3F, 0x41 and 0x80, which separates a range check on the 6-bit field from a check on the whole data word. Collision cases show which index a concurrent data write uses and which half wins bits 43..32.

// File: rtl/aar_pkg.sv
package aar_pkg;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned HALF_W    = 32;
  localparam int unsigned HI_FLD_W  = 12;
  localparam int unsigned HI_FLD_LSB = 32;
  localparam int unsigned SIZE_LSB  = 1;
  localparam int unsigned SIZE_W    = 5;
  localparam int unsigned BASE_LSB  = 12;
  localparam int unsigned BASE_W    = 32;
  localparam logic [DATA_W-1:0] LO_WR_MASK = 64'h0000_0FFF_FFFF_F03F;
  localparam logic [DATA_W-1:0] WIN_RST    = 64'h0000_0000_0000_0022;

  typedef logic [DATA_W-1:0] entry_t;

  typedef struct packed {
    logic              en;
    logic [SIZE_W-1:0] size_exp;
    logic [BASE_W-1:0] base;
  } win_attr_t;

  function automatic win_attr_t decode_win(entry_t e);
    win_attr_t w;
    w.en       = e[0];
    w.size_exp = e[SIZE_LSB +: SIZE_W];
    w.base     = e[BASE_LSB +: BASE_W];
    return w;
  endfunction
endpackage

// File: rtl/aar_index_reg.sv
module aar_index_reg #(
  parameter int unsigned IDX_W       = 6,
  parameter int unsigned NUM_ENTRIES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wval,
  output logic [IDX_W-1:0] idx_q
);
  logic             accept;
  logic             ld_en;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    accept = (wval < IDX_W'(NUM_ENTRIES));
    ld_en  = we & accept;
    idx_d  = ld_en ? wval : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (ld_en) begin
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/aar_entry.sv
module aar_entry
  import aar_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lo_we,
  input  logic   hi_we,
  input  entry_t wdata,
  output entry_t q
);
  entry_t d;
  logic   upd_en;

  always_comb begin
    d      = q;
    upd_en = lo_we | hi_we;
    if (lo_we) begin
      d = wdata & LO_WR_MASK;
    end
    if (hi_we) begin
      d[HI_FLD_LSB +: HI_FLD_W] = wdata[HI_FLD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (upd_en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/aar_read_mux.sv
module aar_read_mux
  import aar_pkg::*;
#(
  parameter int unsigned IDX_W       = 6,
  parameter int unsigned NUM_ENTRIES = 2
) (
  input  logic [NUM_ENTRIES-1:0][DATA_W-1:0] entries,
  input  logic [IDX_W-1:0]                   idx,
  output entry_t                             rd_full,
  output entry_t                             rd_lo,
  output entry_t                             rd_hi
);
  entry_t sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (idx == IDX_W'(i)) begin
        sel = entries[i];
      end
    end
    rd_full = sel;
    rd_lo   = {{(DATA_W-HALF_W){sel[HALF_W-1]}}, sel[HALF_W-1:0]};
    rd_hi   = {{HALF_W{1'b0}}, sel[DATA_W-1:HALF_W]};
  end
endmodule

// File: rtl/aar_regpair.sv
module aar_regpair
  import aar_pkg::*;
#(
  parameter int unsigned IDX_W          = 6,
  parameter int unsigned NUM_ENTRIES    = 2,
  parameter bit          WINDOW_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] rd_full_o,
  output logic [DATA_W-1:0] rd_lo_o,
  output logic [DATA_W-1:0] rd_hi_o,
  output logic              reconf_o,
  output logic              win_en_o,
  output logic [SIZE_W-1:0] win_size_o,
  output logic [BASE_W-1:0] win_base_o
);
  localparam logic [DATA_W-1:0] ENTRY0_RST = WINDOW_PRESENT ? WIN_RST : '0;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [IDX_W-1:0]                   idx_q;
  logic [NUM_ENTRIES-1:0]             hit;
  logic [NUM_ENTRIES-1:0][DATA_W-1:0] ent_q;

  aar_index_reg #(.IDX_W(IDX_W), .NUM_ENTRIES(NUM_ENTRIES)) u_idx (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (idx_we),
    .wval  (wdata[IDX_W-1:0]),
    .idx_q (idx_q)
  );

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      hit[i] = (idx_q == IDX_W'(i));
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    aar_entry #(.RST_VAL((g == 0) ? ENTRY0_RST : '0)) u_ent (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .lo_we (lo_we & hit[g]),
      .hi_we (hi_we & hit[g]),
      .wdata (wdata),
      .q     (ent_q[g])
    );
  end

  aar_read_mux #(.IDX_W(IDX_W), .NUM_ENTRIES(NUM_ENTRIES)) u_rd (
    .entries (ent_q),
    .idx     (idx_q),
    .rd_full (rd_full_o),
    .rd_lo   (rd_lo_o),
    .rd_hi   (rd_hi_o)
  );

  logic reconf_d;
  logic reconf_q;

  always_comb begin
    reconf_d = hit[0] & (lo_we | hi_we);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      reconf_q <= 1'b0;
    end else begin
      reconf_q <= reconf_d;
    end
  end

  win_attr_t win;
  always_comb begin
    win        = decode_win(ent_q[0]);
    win_en_o   = win.en;
    win_size_o = win.size_exp;
    win_base_o = win.base;
    idx_o      = idx_q;
    reconf_o   = reconf_q;
  end
endmodule

// File: rtl/aar_regpair_chk.sv
module aar_regpair_chk
  import aar_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idx_we,
  input logic              lo_we,
  input logic              hi_we,
  input logic [DATA_W-1:0] wdata,
  input logic [IDX_W-1:0]  idx_o,
  input logic [DATA_W-1:0] rd_full_o,
  input logic              reconf_o,
  input logic              win_en_o,
  input logic [SIZE_W-1:0] win_size_o,
  input logic [BASE_W-1:0] win_base_o
);
  // R2
  idx_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we && (wdata[IDX_W-1:0] > IDX_W'(1))) |=> $stable(idx_o));

  // R3
  lo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !hi_we && !idx_we) |=> ((rd_full_o & ~LO_WR_MASK) == '0));

  // R4
  hi_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !lo_we && !idx_we) |=> (rd_full_o[31:0] == $past(rd_full_o[31:0])));

  // R7
  reconf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_we || hi_we) && (idx_o == '0)) |=> reconf_o);

  // R7
  reconf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_o |-> $past((lo_we || hi_we) && (idx_o == '0)));

  // R10
  ent1_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_we || hi_we) && (idx_o == IDX_W'(1))) |=>
      $stable({win_en_o, win_size_o, win_base_o}));
endmodule

bind aar_regpair aar_regpair_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .idx_we     (idx_we),
  .lo_we      (lo_we),
  .hi_we      (hi_we),
  .wdata      (wdata),
  .idx_o      (idx_o),
  .rd_full_o  (rd_full_o),
  .reconf_o   (reconf_o),
  .win_en_o   (win_en_o),
  .win_size_o (win_size_o),
  .win_base_o (win_base_o)
);

// File: tb/tb_aar_regpair.sv
`timescale 1ns/1ps
module tb_aar_regpair;
  logic        clk;
  logic        rst_n;
  logic        idx_we, lo_we, hi_we;
  logic [63:0] wdata;
  logic [5:0]  idx_o;
  logic [63:0] rd_full_o, rd_lo_o, rd_hi_o;
  logic        reconf_o, win_en_o;
  logic [4:0]  win_size_o;
  logic [31:0] win_base_o;

  aar_regpair dut (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .lo_we(lo_we), .hi_we(hi_we),
    .wdata(wdata), .idx_o(idx_o), .rd_full_o(rd_full_o), .rd_lo_o(rd_lo_o),
    .rd_hi_o(rd_hi_o), .reconf_o(reconf_o), .win_en_o(win_en_o),
    .win_size_o(win_size_o), .win_base_o(win_base_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [5:0]  m_idx;
  logic [63:0] m_ent [2];
  logic        m_pulse;

  // stimulus: {idx_we, lo_we, hi_we, wdata}
  localparam int NV = 14;
  localparam logic [66:0] VEC [NV] = '{
    {3'b010, 64'hFFFF_FFFF_FFFF_FFFF},
    {3'b001, 64'hFFFF_FFFF_FFFF_F123},
    {3'b100, 64'h0000_0000_0000_0001},
    {3'b010, 64'h0000_0000_1234_5001},
    {3'b100, 64'h0000_0000_0000_0005},
    {3'b100, 64'h0000_0000_0000_0000},
    {3'b100, 64'h0000_0000_0000_0041},
    {3'b100, 64'h0000_0000_0000_003F},
    {3'b001, 64'h0000_0000_0000_0ABC},
    {3'b100, 64'h0000_0000_0000_0080},
    {3'b010, 64'h0000_0000_7FFF_FFFF},
    {3'b001, 64'hFFFF_FFFF_FFFF_FABC},
    {3'b000, 64'hFFFF_FFFF_FFFF_FFFF},
    {3'b010, 64'h0000_0000_8000_0000}
  };

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [63:0] e;
    e = (m_idx < 2) ? m_ent[m_idx[0]] : 64'h0;
    chk("R2", "index", {58'h0, idx_o}, {58'h0, m_idx});
    chk("R6", "full read", rd_full_o, e);
    chk("R5", "low read", rd_lo_o, {{32{e[31]}}, e[31:0]});
    chk("R6", "high read", rd_hi_o, {32'h0, e[63:32]});
    chk("R7", "reconfigure strobe", {63'h0, reconf_o}, {63'h0, m_pulse});
    chk("R8", "window fields", {26'h0, win_en_o, win_size_o, win_base_o},
        {26'h0, m_ent[0][0], m_ent[0][5:1], m_ent[0][43:12]});
  endtask

  // Called at a negedge; returns at the following negedge with outputs settled.
  task automatic step(input logic iw, input logic lw, input logic hw,
                      input logic [63:0] d);
    logic [5:0] old;
    idx_we = iw; lo_we = lw; hi_we = hw; wdata = d;
    @(negedge clk);
    idx_we = 0; lo_we = 0; hi_we = 0;
    old = m_idx;
    if (old < 2) begin
      if (lw) m_ent[old[0]] = d & 64'h0000_0FFF_FFFF_F03F;
      if (hw) m_ent[old[0]][43:32] = d[11:0];
    end
    if (iw && d[5:0] < 6'd2) m_idx = d[5:0];
    m_pulse = (lw || hw) && (old == 6'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; idx_we = 0; lo_we = 0; hi_we = 0; wdata = '0;
    m_idx = 0; m_ent[0] = 64'h22; m_ent[1] = 64'h0; m_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", "entry0 reset", rd_full_o, 64'h22);
    chk("R1", "size exponent reset", {59'h0, win_size_o}, 64'd17);
    chk("R1", "enable reset", {63'h0, win_en_o}, 64'h0);
    chk("R1", "index reset", {58'h0, idx_o}, 64'h0);
    chk("R1", "strobe reset", {63'h0, reconf_o}, 64'h0);
    step(1, 0, 0, 64'h1);
    chk("R1", "entry1 reset", rd_full_o, 64'h0);
    step(1, 0, 0, 64'h0);

    // Table-driven main function: R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][66], VEC[i][65], VEC[i][64], VEC[i][63:0]);
      check_all();
    end

    // R3 directed: all-ones low write yields the mask exactly
    step(1, 0, 0, 64'h0);
    step(0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3", "mask", rd_full_o, 64'h0000_0FFF_FFFF_F03F);
    // R4 directed: high write keeps low word
    step(0, 0, 1, 64'h0000_0000_0000_0555);
    chk("R4", "high write", rd_full_o, 64'h0000_0555_FFFF_F03F);
    step(0, 0, 0, 64'h0);
    chk("R7", "strobe single cycle", {63'h0, reconf_o}, 64'h0);

    // R9: index write with data write goes to old entry
    step(1, 1, 0, 64'h0000_0000_0000_0001);
    check_all();
    chk("R9", "entry0 got concurrent data", {63'h0, win_en_o}, 64'h1);
    chk("R9", "index moved", {58'h0, idx_o}, 64'h1);
    // R9: low and high together, high wins 43..32
    step(0, 1, 1, 64'h0000_0ABC_0000_0123);
    check_all();
    chk("R9", "lo+hi collision", rd_full_o, 64'h0000_0123_0000_0023);

    // R10: entry 1 write leaves window outputs alone
    step(0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    check_all();
    chk("R10", "window base unchanged", {32'h0, win_base_o}, {32'h0, m_ent[0][43:12]});
    chk("R10", "no strobe for entry1", {63'h0, reconf_o}, 64'h0);

    finish_run();
  end
endmodule